// File: doc/BRIEF.md
# Two-Subphase Address Parity Generator and Checker

This block produces and verifies the two address parity bits of a shared multi-agent bus. An address phase lasts two clocks. In the first clock the address pins carry the physical address. In the second clock the same pins carry transaction-type information. A 5-bit request field accompanies both clocks. Every signal in the covered set is active low. Each parity bit is defined on electrical levels, so a set of covered signals that are all high gives a high parity bit.

On the requesting side, the block watches the address strobe. It computes parity for each subphase and drives it onto the parity pins one clock after the matching address and request values. On the receiving side, it recomputes parity from the observed address and request values. It compares that result with the parity bits that arrive one clock later. Any mismatch raises a one-clock error pulse for each bit, tagged with the subphase number. A strobe that arrives while a phase is still open is refused and reported as a protocol error. The two parity bits share the two signal groups between them, and which bit covers which group swaps from subphase 1 to subphase 2.

Top module: `addr_par_unit`

## Requirements
- R1: Each parity bit is 1 when an even number of the signals it covers are 0, and 0 when that number is odd. With all covered signals at 1, both parity bits are 1.
- R2: In subphase 1, parity bit 0 covers address bits [39:24]. Parity bit 1 covers address bits [23:3] together with the request field.
- R3: In subphase 2, parity bit 1 covers address bits [39:24]. Parity bit 0 covers address bits [23:3] together with the request field.
- R4: When no phase is open, a strobe sampled low at a rising clock edge opens a phase. The clock in which the strobe is low is subphase 1, and the next clock is subphase 2. A new strobe in the clock after subphase 2 is accepted again.
- R5: `tx_par_n_o` carries the subphase-1 parity in the clock after the strobe and the subphase-2 parity in the clock after that. At all other times it is 2'b11.
- R6: The receiver samples the parity pins one clock after each subphase. It raises `rx_err_o[i]` for exactly one clock, in the following clock, for each bit i that differs from the recomputed value. While any error bit is set, `rx_err_sub_o` is 0 for subphase 1 and 1 for subphase 2.
- R7: When the received parity matches, or when no phase is being checked, `rx_err_o` is 2'b00.
- R8: A strobe that is low during subphase 2 is not accepted. The matching protocol-error output pulses for one clock in the clock that follows. The open phase completes unchanged, and no new phase starts.
- R9: While `rst_ni` is low, no phase is open, `tx_par_n_o` is 2'b11, and all error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_strb_n_i | input | 1 | Requestor address strobe, active low |
| tx_addr_n_i | input | 37 | Requestor address bits [39:3], active low |
| tx_req_n_i | input | 5 | Requestor request field, active low |
| tx_par_n_o | output | 2 | Generated parity bits, active low, 2'b11 when idle |
| tx_proto_err_o | output | 1 | Requestor strobe refused during an open phase |
| rx_strb_n_i | input | 1 | Observed address strobe, active low |
| rx_addr_n_i | input | 37 | Observed address bits [39:3], active low |
| rx_req_n_i | input | 5 | Observed request field, active low |
| rx_par_n_i | input | 2 | Observed parity bits, active low |
| rx_err_o | output | 2 | Mismatch pulse for each parity bit |
| rx_err_sub_o | output | 1 | Subphase of the reported mismatch (0 = first, 1 = second) |
| rx_proto_err_o | output | 1 | Observed strobe refused during an open phase |

## Verification
The bench builds the block with its default parameters: address bits 39 down to 3, the group split at bit 24, and a 5-bit request field. With these values, single low bits placed on either side of the split (bits 24 and 23) and in the request field show the coverage swap directly as fixed expected codes. Error injection on each parity bit separately, in each subphase, exercises the subphase tag. Strobes held low for two clocks test the refusal path. Strobes spaced one clock apart test re-acceptance immediately after subphase 2.

// File: rtl/addr_par_pkg.sv
package addr_par_pkg;
  localparam int ADDR_HI_D = 39;
  localparam int ADDR_LO_D = 3;
  localparam int SPLIT_D   = 24;
  localparam int REQ_W_D   = 5;

  typedef enum logic {
    SUB_ONE = 1'b0,
    SUB_TWO = 1'b1
  } subphase_e;
endpackage

// File: rtl/addr_par_calc.sv
// Electrical-level parity of the two groups, routed by subphase.
module addr_par_calc #(
  parameter int ADDR_HI = 39,
  parameter int ADDR_LO = 3,
  parameter int SPLIT   = 24,
  parameter int REQ_W   = 5
) (
  input  logic [ADDR_HI:ADDR_LO] addr_n_i,
  input  logic [REQ_W-1:0]       req_n_i,
  input  logic                   sub2_i,
  output logic [1:0]             par_n_o
);
  localparam int HI_W = ADDR_HI - SPLIT + 1;
  localparam int LO_W = SPLIT - ADDR_LO + REQ_W;

  logic [HI_W-1:0] hi_grp;
  logic [LO_W-1:0] lo_grp;
  logic            p_hi, p_lo;

  assign hi_grp = addr_n_i[ADDR_HI:SPLIT];
  assign lo_grp = {addr_n_i[SPLIT-1:ADDR_LO], req_n_i};

  // high when the count of low signals is even
  assign p_hi = ~(^(~hi_grp));
  assign p_lo = ~(^(~lo_grp));

  assign par_n_o = sub2_i ? {p_hi, p_lo} : {p_lo, p_hi};
endmodule

// File: rtl/addr_par_phase.sv
// Two-clock address phase tracker with refusal of overlapping strobes.
module addr_par_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_n_i,
  output logic sub1_o,
  output logic sub2_o,
  output logic proto_err_o
);
  logic sub2_q, proto_q;

  assign sub1_o      = ~strb_n_i & ~sub2_q;
  assign sub2_o      = sub2_q;
  assign proto_err_o = proto_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub2_q  <= 1'b0;
      proto_q <= 1'b0;
    end else begin
      sub2_q  <= sub1_o;
      proto_q <= ~strb_n_i & sub2_q;
    end
  end
endmodule

// File: rtl/addr_par_gen.sv
// Requestor side: parity registered one clock behind its subphase.
module addr_par_gen #(
  parameter int ADDR_HI = 39,
  parameter int ADDR_LO = 3,
  parameter int SPLIT   = 24,
  parameter int REQ_W   = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sub1_i,
  input  logic                   sub2_i,
  input  logic [ADDR_HI:ADDR_LO] addr_n_i,
  input  logic [REQ_W-1:0]       req_n_i,
  output logic [1:0]             par_n_o
);
  logic [1:0] par_d, par_q;

  addr_par_calc #(
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
  ) u_calc (
    .addr_n_i(addr_n_i),
    .req_n_i (req_n_i),
    .sub2_i  (sub2_i),
    .par_n_o (par_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               par_q <= 2'b11;
    else if (sub1_i || sub2_i) par_q <= par_d;
    else                       par_q <= 2'b11;
  end

  assign par_n_o = par_q;
endmodule

// File: rtl/addr_par_chk.sv
// Receiver side: hold expected parity one clock, compare on arrival.
module addr_par_chk
  import addr_par_pkg::*;
#(
  parameter int ADDR_HI = 39,
  parameter int ADDR_LO = 3,
  parameter int SPLIT   = 24,
  parameter int REQ_W   = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sub1_i,
  input  logic                   sub2_i,
  input  logic [ADDR_HI:ADDR_LO] addr_n_i,
  input  logic [REQ_W-1:0]       req_n_i,
  input  logic [1:0]             par_n_i,
  output logic [1:0]             err_o,
  output logic                   err_sub_o
);
  logic [1:0] exp_d, exp_q, err_q;
  logic       pend_q;
  subphase_e  pend_sub_q, err_sub_q;

  addr_par_calc #(
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
  ) u_calc (
    .addr_n_i(addr_n_i),
    .req_n_i (req_n_i),
    .sub2_i  (sub2_i),
    .par_n_o (exp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q      <= 2'b11;
      pend_q     <= 1'b0;
      pend_sub_q <= SUB_ONE;
      err_q      <= 2'b00;
      err_sub_q  <= SUB_ONE;
    end else begin
      exp_q      <= exp_d;
      pend_q     <= sub1_i | sub2_i;
      pend_sub_q <= sub2_i ? SUB_TWO : SUB_ONE;
      if (pend_q) begin
        err_q     <= exp_q ^ par_n_i;
        err_sub_q <= pend_sub_q;
      end else begin
        err_q     <= 2'b00;
        err_sub_q <= SUB_ONE;
      end
    end
  end

  assign err_o     = err_q;
  assign err_sub_o = err_sub_q;
endmodule

// File: rtl/addr_par_unit.sv
module addr_par_unit
  import addr_par_pkg::*;
#(
  parameter int ADDR_HI = ADDR_HI_D,
  parameter int ADDR_LO = ADDR_LO_D,
  parameter int SPLIT   = SPLIT_D,
  parameter int REQ_W   = REQ_W_D
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tx_strb_n_i,
  input  logic [ADDR_HI:ADDR_LO] tx_addr_n_i,
  input  logic [REQ_W-1:0]       tx_req_n_i,
  output logic [1:0]             tx_par_n_o,
  output logic                   tx_proto_err_o,
  input  logic                   rx_strb_n_i,
  input  logic [ADDR_HI:ADDR_LO] rx_addr_n_i,
  input  logic [REQ_W-1:0]       rx_req_n_i,
  input  logic [1:0]             rx_par_n_i,
  output logic [1:0]             rx_err_o,
  output logic                   rx_err_sub_o,
  output logic                   rx_proto_err_o
);
  logic tx_sub1, tx_sub2, rx_sub1, rx_sub2;

  addr_par_phase u_tx_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_n_i(tx_strb_n_i),
    .sub1_o(tx_sub1), .sub2_o(tx_sub2), .proto_err_o(tx_proto_err_o)
  );

  addr_par_phase u_rx_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_n_i(rx_strb_n_i),
    .sub1_o(rx_sub1), .sub2_o(rx_sub2), .proto_err_o(rx_proto_err_o)
  );

  addr_par_gen #(
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
  ) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .sub1_i(tx_sub1), .sub2_i(tx_sub2),
    .addr_n_i(tx_addr_n_i), .req_n_i(tx_req_n_i), .par_n_o(tx_par_n_o)
  );

  addr_par_chk #(
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO), .SPLIT(SPLIT), .REQ_W(REQ_W)
  ) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .sub1_i(rx_sub1), .sub2_i(rx_sub2),
    .addr_n_i(rx_addr_n_i), .req_n_i(rx_req_n_i), .par_n_i(rx_par_n_i),
    .err_o(rx_err_o), .err_sub_o(rx_err_sub_o)
  );
endmodule

// File: rtl/addr_par_unit_sva.sv
module addr_par_unit_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_sub1_i,
  input logic       tx_sub2_i,
  input logic       rx_sub1_i,
  input logic       rx_sub2_i,
  input logic [1:0] tx_par_n_i,
  input logic       tx_proto_err_i,
  input logic       rx_proto_err_i,
  input logic [1:0] rx_err_i
);
  AST_TX_SUB2_AFTER_SUB1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sub1_i |=> tx_sub2_i); // R4
  AST_TX_PAR_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_sub1_i || tx_sub2_i) |-> tx_par_n_i == 2'b11); // R5
  AST_ERR_NEEDS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_i != 2'b00) |-> $past(rx_sub1_i || rx_sub2_i, 2)); // R6
  AST_TX_REFUSED_NO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_proto_err_i |-> !tx_sub2_i); // R8
  AST_RX_REFUSED_NO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_proto_err_i |-> !rx_sub2_i); // R8
endmodule

bind addr_par_unit addr_par_unit_sva u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tx_sub1_i     (tx_sub1),
  .tx_sub2_i     (tx_sub2),
  .rx_sub1_i     (rx_sub1),
  .rx_sub2_i     (rx_sub2),
  .tx_par_n_i    (tx_par_n_o),
  .tx_proto_err_i(tx_proto_err_o),
  .rx_proto_err_i(rx_proto_err_o),
  .rx_err_i      (rx_err_o)
);

// File: tb/sim_addr_par_unit.sv
module sim_addr_par_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;
  localparam logic [39:3] ONES_A = '1;
  localparam logic [4:0]  ONES_R = '1;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        tx_strb_n_i, rx_strb_n_i;
  logic [39:3] tx_addr_n_i, rx_addr_n_i;
  logic [4:0]  tx_req_n_i, rx_req_n_i;
  logic [1:0]  tx_par_n_o, rx_par_n_i, rx_err_o;
  logic        tx_proto_err_o, rx_err_sub_o, rx_proto_err_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addr_par_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tx_strb_n_i(tx_strb_n_i), .tx_addr_n_i(tx_addr_n_i), .tx_req_n_i(tx_req_n_i),
    .tx_par_n_o(tx_par_n_o), .tx_proto_err_o(tx_proto_err_o),
    .rx_strb_n_i(rx_strb_n_i), .rx_addr_n_i(rx_addr_n_i), .rx_req_n_i(rx_req_n_i),
    .rx_par_n_i(rx_par_n_i), .rx_err_o(rx_err_o), .rx_err_sub_o(rx_err_sub_o),
    .rx_proto_err_o(rx_proto_err_o)
  );

  // 1 when the count of zeros among the low n bits is even (R1)
  function automatic logic grp_par(input logic [63:0] v, input int n);
    int z = 0;
    for (int i = 0; i < n; i++) if (!v[i]) z++;
    return (z % 2) == 0;
  endfunction

  // R2 / R3 coverage
  function automatic logic [1:0] exp_par(input logic [39:3] a, input logic [4:0] r,
                                         input bit sub2);
    logic ph, pl;
    ph = grp_par({48'd0, a[39:24]}, 16);
    pl = grp_par({38'd0, a[23:3], r}, 26);
    return sub2 ? {ph, pl} : {pl, ph};
  endfunction

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic drive(input logic strb, input logic [39:3] a, input logic [4:0] r);
    tx_strb_n_i = strb; rx_strb_n_i = strb;
    tx_addr_n_i = a;    rx_addr_n_i = a;
    tx_req_n_i  = r;    rx_req_n_i  = r;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R4 watchdog actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic t_reset();
    rst_ni = 1'b0;
    drive(1'b0, '0, '0);
    rx_par_n_i = 2'b00;
    tick(); tick();
    chk(tx_par_n_o, 2'b11, "R9 tx_par in reset");
    chk(rx_err_o, 2'b00, "R9 rx_err in reset");
    chk({tx_proto_err_o, rx_proto_err_o}, 2'b00, "R9 proto in reset");
    drive(1'b1, ONES_A, ONES_R);
    rx_par_n_i = 2'b11;
    rst_ni = 1'b1;
    tick();
    chk(tx_par_n_o, 2'b11, "R9 tx_par after release");
    chk(rx_err_o, 2'b00, "R9 rx_err after release");
  endtask

  // full phase; e1/e2 expected parity, i1/i2 injected flips on rx
  task automatic run_phase(input logic [39:3] a1, input logic [4:0] r1,
                           input logic [39:3] a2, input logic [4:0] r2,
                           input logic [1:0] e1, input logic [1:0] e2,
                           input logic [1:0] i1, input logic [1:0] i2,
                           input string tag);
    drive(1'b0, a1, r1); rx_par_n_i = 2'b11;
    tick();
    chk(tx_par_n_o, e1, {"R2 sub1 parity ", tag});
    drive(1'b1, a2, r2); rx_par_n_i = e1 ^ i1;
    tick();
    chk(tx_par_n_o, e2, {"R3 sub2 parity ", tag});
    chk(rx_err_o, i1, {"R6 sub1 err ", tag});
    if (i1 != 2'b00) chk({1'b0, rx_err_sub_o}, 2'b00, {"R6 sub tag 1 ", tag});
    drive(1'b1, ONES_A, ONES_R); rx_par_n_i = e2 ^ i2;
    tick();
    chk(tx_par_n_o, 2'b11, {"R5 idle after phase ", tag});
    chk(rx_err_o, i2, {"R6 sub2 err ", tag});
    if (i2 != 2'b00) chk({1'b0, rx_err_sub_o}, 2'b01, {"R6 sub tag 2 ", tag});
    rx_par_n_i = 2'b11;
    tick();
    chk(rx_err_o, 2'b00, {"R7 err cleared ", tag});
  endtask

  task automatic t_polarity();
    run_phase(ONES_A, ONES_R, ONES_A, ONES_R, 2'b11, 2'b11, 2'b00, 2'b00, "R1 all high");
    run_phase('0, '0, '0, '0, exp_par('0, '0, 0), exp_par('0, '0, 1),
              2'b00, 2'b00, "R1 all low");
  endtask

  task automatic t_coverage();
    logic [39:3] a39, a24, a23;
    a39 = ONES_A; a39[39] = 1'b0;
    a24 = ONES_A; a24[24] = 1'b0;
    a23 = ONES_A; a23[23] = 1'b0;
    run_phase(a39, ONES_R, a39, ONES_R, 2'b10, 2'b01, 2'b00, 2'b00, "R2 R3 bit39");
    run_phase(a24, ONES_R, a23, ONES_R, 2'b10, 2'b10, 2'b00, 2'b00, "R2 R3 bit24 bit23");
    run_phase(a23, ONES_R, a24, ONES_R, 2'b01, 2'b01, 2'b00, 2'b00, "R2 R3 bit23 bit24");
    run_phase(ONES_A, 5'b11110, ONES_A, 5'b11110, 2'b01, 2'b10, 2'b00, 2'b00, "R2 R3 req0");
  endtask

  task automatic t_errors();
    logic [39:3] a1, a2;
    a1 = 37'h0A5A5_1234; a2 = 37'h1F00F_0F0F;
    run_phase(a1, 5'h13, a2, 5'h0C, exp_par(a1, 5'h13, 0), exp_par(a2, 5'h0C, 1),
              2'b01, 2'b00, "R6 flip0 sub1");
    run_phase(a1, 5'h13, a2, 5'h0C, exp_par(a1, 5'h13, 0), exp_par(a2, 5'h0C, 1),
              2'b00, 2'b10, "R6 flip1 sub2");
    run_phase(a2, 5'h01, a1, 5'h1E, exp_par(a2, 5'h01, 0), exp_par(a1, 5'h1E, 1),
              2'b11, 2'b01, "R6 both flips");
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) begin
      logic [39:3] a1, a2;
      logic [4:0]  r1, r2;
      a1 = {$urandom, $urandom}; a2 = {$urandom, $urandom};
      r1 = 5'($urandom); r2 = 5'($urandom);
      run_phase(a1, r1, a2, r2, exp_par(a1, r1, 0), exp_par(a2, r2, 1),
                2'(i % 4), 2'((i / 4) % 4), "R2 R3 R6 random");
    end
  endtask

  task automatic t_proto();
    logic [39:3] a1, a2;
    logic [1:0]  e1, e2;
    a1 = 37'h1_2345_6789; a2 = 37'h0_FEDC_BA98;
    e1 = exp_par(a1, 5'h05, 0); e2 = exp_par(a2, 5'h1A, 1);
    drive(1'b0, a1, 5'h05); rx_par_n_i = 2'b11;
    tick();
    chk(tx_par_n_o, e1, "R8 first sub1");
    drive(1'b0, a2, 5'h1A); rx_par_n_i = e1;
    tick();
    chk({tx_proto_err_o, rx_proto_err_o}, 2'b11, "R8 proto pulse");
    chk(tx_par_n_o, e2, "R8 open phase unchanged");
    chk(rx_err_o, 2'b00, "R7 no err sub1");
    drive(1'b1, ONES_A, ONES_R); rx_par_n_i = e2;
    tick();
    chk(tx_par_n_o, 2'b11, "R8 no new phase");
    chk({tx_proto_err_o, rx_proto_err_o}, 2'b00, "R8 proto one clock");
    chk(rx_err_o, 2'b00, "R7 no err sub2");
    rx_par_n_i = 2'b11;
    tick();
    chk(rx_err_o, 2'b00, "R8 rx no extra phase");
  endtask

  task automatic t_back2back();
    logic [39:3] a1, a2, b1, b2;
    logic [1:0]  e1, e2, f1, f2;
    a1 = 37'h0_1111_2222; a2 = 37'h1_3333_4444;
    b1 = 37'h0_5555_6666; b2 = 37'h1_7777_8888;
    e1 = exp_par(a1, 5'h11, 0); e2 = exp_par(a2, 5'h02, 1);
    f1 = exp_par(b1, 5'h07, 0); f2 = exp_par(b2, 5'h18, 1);
    drive(1'b0, a1, 5'h11); rx_par_n_i = 2'b11;
    tick();
    chk(tx_par_n_o, e1, "R4 first sub1");
    drive(1'b1, a2, 5'h02); rx_par_n_i = e1;
    tick();
    chk(tx_par_n_o, e2, "R4 first sub2");
    drive(1'b0, b1, 5'h07); rx_par_n_i = e2;
    tick();
    chk(tx_par_n_o, f1, "R4 reaccept sub1");
    chk({tx_proto_err_o, rx_proto_err_o}, 2'b00, "R4 no proto on reaccept");
    chk(rx_err_o, 2'b00, "R7 back2back err a");
    drive(1'b1, b2, 5'h18); rx_par_n_i = f1;
    tick();
    chk(tx_par_n_o, f2, "R4 reaccept sub2");
    chk(rx_err_o, 2'b00, "R7 back2back err b");
    drive(1'b1, ONES_A, ONES_R); rx_par_n_i = f2;
    tick();
    chk(tx_par_n_o, 2'b11, "R5 idle after back2back");
    chk(rx_err_o, 2'b00, "R7 back2back err c");
    rx_par_n_i = 2'b11;
    tick();
    chk(rx_err_o, 2'b00, "R7 back2back err d");
  endtask

  initial begin
    t_reset();
    t_polarity();
    t_coverage();
    t_errors();
    t_proto();
    t_back2back();
    t_random();
    done = 1;
    summary();
    $finish;
  end
endmodule